// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Return-Address Stack

This block is the control path that brings instructions in from a synchronous instruction memory and keeps the program counter. Each memory byte is fetched in four cycles. First the program counter is copied into the address register that drives the memory. The block then waits one cycle for the memory to return data. Next it captures the read byte into the instruction register. Last it advances the program counter by one. In the default configuration an instruction is two bytes, so the fetch sequence runs twice. The first byte goes into the low half of the instruction register and the second byte into the high half.

Once the instruction register is complete, the block pulses a fetch-done strobe and waits in an execute step. An external decoder examines the instruction and answers with a done handshake. The handshake carries optional flow-control requests: jump, call or return, with a target address. A call saves the program counter, which already points past the call instruction, on an internal return-address stack. The stack writes at the stack pointer and then increments it. A return decrements the pointer and then reads. A call on a full stack, or a return on an empty stack, raises a sticky error flag and leaves the program counter alone.

Top module: `fetch_seq`

## Requirements
- R1: While reset is asserted, the program counter equals `start_addr`, the instruction register is zero, `fetch_done` is low, `stk_err` is low and the return stack is empty.
- R2: Each byte takes four cycles: address, memory wait, capture and increment. `mem_addr` takes the program counter value one cycle after the address cycle begins. With two-byte instructions, `fetch_done` is first seen 9 cycles after the cycle in which `ex_done` was accepted.
- R3: In the two-byte configuration, after a fetch from address A, `ir_q[7:0]` holds the byte at A, `ir_q[15:8]` holds the byte at A+1 and the program counter equals A+2, all modulo 2^ADDR_W.
- R4: In the one-byte configuration, after a fetch from address A, `ir_q` holds the byte at A and the program counter equals A+1, wrapping from the top address to 0.
- R5: `fetch_done` is high for exactly one cycle per fetched instruction. Until `ex_done` is high, the program counter and `ir_q` hold and no new fetch starts.
- R6: An accepted `ex_done` with `ex_jump` alone loads `ex_target` into the program counter. The change happens at the execute step, and the next fetch comes from the target.
- R7: An accepted `ex_done` with `ex_call` on a non-full stack pushes the current program counter and loads `ex_target`.
- R8: An accepted `ex_done` with `ex_ret` on a non-empty stack loads the most recently pushed address. Nested returns restore addresses in reverse order of the calls.
- R9: A call while STK_DEPTH addresses are held sets `stk_err` and leaves the program counter and stack unchanged.
- R10: A return on an empty stack sets `stk_err` and leaves the program counter and stack unchanged.
- R11: Once set, `stk_err` stays high until reset.
- R12: When several requests are high together, call wins over return, and return wins over jump.
- R13: An accepted `ex_done` with no request leaves the program counter unchanged, so the next fetch continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | ADDR_W | Program counter value loaded during reset |
| mem_addr | output | ADDR_W | Registered instruction memory address |
| mem_rdata | input | BYTE_W | Memory read data, valid one cycle after the address is presented |
| ex_done | input | 1 | Execute step finished; sampled only while waiting |
| ex_jump | input | 1 | Jump request |
| ex_call | input | 1 | Subroutine call request |
| ex_ret | input | 1 | Subroutine return request |
| ex_target | input | ADDR_W | Jump or call destination |
| fetch_done | output | 1 | One-cycle strobe: instruction register is valid |
| ir_q | output | 8*IR_BYTES | Assembled instruction register |
| pc_q | output | ADDR_W | Program counter |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A wrong phase or byte-select value shows up at the ports within one fetch. It appears as a `mem_addr` value or fetch length that is off, or as swapped bytes in `ir_q` at the next `fetch_done`. A corrupted stack pointer or stack entry stays hidden until the matching return. At that point `pc_q` takes a wrong address in the same cycle, and the following fetch reads bytes that do not match that address. For this reason the bench nests calls to full depth and unwinds them completely, comparing `pc_q` after every execute step.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

   typedef enum logic [2:0] {
      PH_ADDR = 3'd0,
      PH_WAIT = 3'd1,
      PH_MEM  = 3'd2,
      PH_INC  = 3'd3,
      PH_EXEC = 3'd4
   } fseq_phase_e;

   typedef struct packed {
      logic jump;
      logic call;
      logic ret;
   } fseq_flow_t;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_JUMP = 2'd1,
      ACT_CALL = 2'd2,
      ACT_RET  = 2'd3
   } fseq_act_e;

   function automatic fseq_act_e pick_action(input fseq_flow_t f);
      if (f.call)      return ACT_CALL;
      else if (f.ret)  return ACT_RET;
      else if (f.jump) return ACT_JUMP;
      else             return ACT_NONE;
   endfunction

endpackage

// File: rtl/fseq_pc.sv
module fseq_pc #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              inc_en,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] pc_q
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= start_addr;
      else if (load_en) pc_q <= load_val;
      else if (inc_en)  pc_q <= pc_q + STEP;
   end

endmodule

// File: rtl/fseq_ir.sv
module fseq_ir #(
   parameter int BYTE_W   = 8,
   parameter int IR_BYTES = 2,
   parameter int SEL_W    = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cap_en,
   input  logic [SEL_W-1:0]           sel,
   input  logic [BYTE_W-1:0]          byte_in,
   output logic [BYTE_W*IR_BYTES-1:0] ir_q
);

   for (genvar g = 0; g < IR_BYTES; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               slot_q <= '0;
         else if (cap_en && (sel == SEL_W'(g)))    slot_q <= byte_in;
      end
      assign ir_q[g*BYTE_W +: BYTE_W] = slot_q;
   end

endmodule

// File: rtl/fseq_rstack.sv
module fseq_rstack #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 8,
   parameter int SP_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_val,
   output logic [ADDR_W-1:0] top_val,
   output logic              full,
   output logic              empty,
   output logic [SP_W-1:0]   level
);

   localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [SP_W-1:0] LVL_FULL = SP_W'(DEPTH);
   localparam logic [SP_W-1:0] LVL_ONE  = SP_W'(1);

   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [SP_W-1:0]   sp_q;
   logic [IX_W-1:0]   wr_ix;
   logic [IX_W-1:0]   rd_ix;

   assign wr_ix = sp_q[IX_W-1:0];
   assign rd_ix = IX_W'(sp_q - LVL_ONE);
   assign full  = (sp_q == LVL_FULL);
   assign empty = (sp_q == '0);
   assign level = sp_q;
   assign top_val = empty ? '0 : slot_q[rd_ix];

   // write at the pointer, then advance it
   always_ff @(posedge clk) begin
      if (push && !full) slot_q[wr_ix] <= push_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sp_q <= '0;
      else if (push && !pop && !full)     sp_q <= sp_q + LVL_ONE;
      else if (pop && !push && !empty)    sp_q <= sp_q - LVL_ONE;
   end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
   import fetch_seq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int IR_BYTES  = 2,
   parameter int STK_DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          start_addr,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic [BYTE_W-1:0]          mem_rdata,
   input  logic                       ex_done,
   input  logic                       ex_jump,
   input  logic                       ex_call,
   input  logic                       ex_ret,
   input  logic [ADDR_W-1:0]          ex_target,
   output logic                       fetch_done,
   output logic [BYTE_W*IR_BYTES-1:0] ir_q,
   output logic [ADDR_W-1:0]          pc_q,
   output logic                       stk_err
);

   localparam int SEL_W = (IR_BYTES > 1) ? $clog2(IR_BYTES) : 1;
   localparam int SP_W  = $clog2(STK_DEPTH + 1);
   localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(IR_BYTES - 1);

   if (IR_BYTES < 1 || IR_BYTES > 2) begin : g_bad_ir
      $error("fetch_seq: IR_BYTES must be 1 or 2");
   end
   if (STK_DEPTH < 2) begin : g_bad_depth
      $error("fetch_seq: STK_DEPTH must be at least 2");
   end
   if (ADDR_W < 2 || BYTE_W < 1) begin : g_bad_width
      $error("fetch_seq: widths too small");
   end

   fseq_phase_e       phase_q, phase_d;
   logic [SEL_W-1:0]  bsel_q;
   logic              last_byte;
   logic [ADDR_W-1:0] mar_q;
   logic              done_q;
   logic              err_q;

   fseq_flow_t        flow;
   fseq_act_e         act;
   logic              exec_go;
   logic              stk_full, stk_empty;
   logic [SP_W-1:0]   sp_lvl;
   logic [ADDR_W-1:0] stk_top;
   logic              do_push, do_pop, do_jump, err_set;
   logic              pc_load;
   logic [ADDR_W-1:0] pc_load_val;

   // ---------------- phase sequencer ----------------
   assign last_byte = (bsel_q == SEL_LAST);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_ADDR: phase_d = PH_WAIT;
         PH_WAIT: phase_d = PH_MEM;
         PH_MEM:  phase_d = PH_INC;
         PH_INC:  phase_d = last_byte ? PH_EXEC : PH_ADDR;
         PH_EXEC: phase_d = ex_done ? PH_ADDR : PH_EXEC;
         default: phase_d = PH_ADDR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_ADDR;
      else        phase_q <= phase_d;
   end

   if (IR_BYTES == 1) begin : g_single
      assign bsel_q = '0;
   end else begin : g_multi
      logic [SEL_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (phase_q == PH_INC) cnt_q <= last_byte ? '0 : cnt_q + SEL_W'(1);
      end
      assign bsel_q = cnt_q;
   end

   // address register feeding the memory
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mar_q <= '0;
      else if (phase_q == PH_ADDR) mar_q <= pc_q;
   end
   assign mem_addr = mar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= (phase_q == PH_INC) && last_byte;
   end
   assign fetch_done = done_q;

   // ---------------- execute step ----------------
   assign flow    = '{jump: ex_jump, call: ex_call, ret: ex_ret};
   assign act     = pick_action(flow);
   assign exec_go = (phase_q == PH_EXEC) && ex_done;

   assign do_push = exec_go && (act == ACT_CALL) && !stk_full;
   assign do_pop  = exec_go && (act == ACT_RET)  && !stk_empty;
   assign do_jump = exec_go && (act == ACT_JUMP);
   assign err_set = exec_go && (((act == ACT_CALL) && stk_full) ||
                                ((act == ACT_RET)  && stk_empty));

   assign pc_load     = do_push || do_pop || do_jump;
   assign pc_load_val = do_pop ? stk_top : ex_target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | err_set;
   end
   assign stk_err = err_q;

   // ---------------- sub-blocks ----------------
   fseq_pc #(.ADDR_W(ADDR_W)) pc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_addr),
      .inc_en     (phase_q == PH_INC),
      .load_en    (pc_load),
      .load_val   (pc_load_val),
      .pc_q       (pc_q)
   );

   fseq_ir #(.BYTE_W(BYTE_W), .IR_BYTES(IR_BYTES), .SEL_W(SEL_W)) ir_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (phase_q == PH_MEM),
      .sel     (bsel_q),
      .byte_in (mem_rdata),
      .ir_q    (ir_q)
   );

   fseq_rstack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH), .SP_W(SP_W)) stk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (do_push),
      .pop      (do_pop),
      .push_val (pc_q),
      .top_val  (stk_top),
      .full     (stk_full),
      .empty    (stk_empty),
      .level    (sp_lvl)
   );

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk
   import fetch_seq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SP_W   = 4,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input fseq_phase_e       phase,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] mar,
   input logic [SP_W-1:0]   level,
   input logic              err,
   input logic              fetch_done,
   input logic              ex_done,
   input logic              ex_call,
   input logic              ex_ret
);

   localparam logic [SP_W-1:0] LVL_FULL = SP_W'(DEPTH);

   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INC) |=> (pc == $past(pc) + ADDR_W'(1)));

   a_r2_mar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_ADDR) |=> $stable(mar));

   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |=> !fetch_done);

   a_r5_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && !ex_done) |=> $stable(pc));

   a_r9_full_call: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && ex_done && ex_call && level == LVL_FULL)
      |=> (err && $stable(pc) && $stable(level)));

   a_r10_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && ex_done && !ex_call && ex_ret && level == '0)
      |=> (err && $stable(pc) && $stable(level)));

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_FULL);

endmodule

bind fetch_seq fetch_seq_chk #(
   .ADDR_W (ADDR_W),
   .SP_W   (SP_W),
   .DEPTH  (STK_DEPTH)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase      (phase_q),
   .pc         (pc_q),
   .mar        (mar_q),
   .level      (sp_lvl),
   .err        (stk_err),
   .fetch_done (fetch_done),
   .ex_done    (ex_done),
   .ex_call    (ex_call),
   .ex_ret     (ex_ret)
);

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit main_done = 1'b0;
   bit nar_done  = 1'b0;

   function automatic logic [7:0] memf(input logic [7:0] a);
      return (a * 8'd37) + 8'd11;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- main DUT: two-byte instructions ----------------
   logic        rst_n = 1'b0;
   logic [7:0]  start_addr = 8'h40;
   logic [7:0]  mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        ex_done = 0, ex_jump = 0, ex_call = 0, ex_ret = 0;
   logic [7:0]  ex_target = '0;
   logic        fetch_done;
   logic [15:0] ir_q;
   logic [7:0]  pc_q;
   logic        stk_err;

   always @(posedge clk) mem_rdata <= memf(mem_addr);

   fetch_seq #(.ADDR_W(8), .BYTE_W(8), .IR_BYTES(2), .STK_DEPTH(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .ex_done(ex_done), .ex_jump(ex_jump), .ex_call(ex_call), .ex_ret(ex_ret),
      .ex_target(ex_target), .fetch_done(fetch_done), .ir_q(ir_q),
      .pc_q(pc_q), .stk_err(stk_err)
   );

   // ---------------- second DUT: one-byte instructions ----------------
   logic       rst_w_n = 1'b0;
   logic [7:0] fw_addr, fw_rdata = '0, fw_ir, fw_pc;
   logic       fw_done, fw_err;
   localparam logic [7:0] SW = 8'hF6;

   always @(posedge clk) fw_rdata <= memf(fw_addr);

   fetch_seq #(.ADDR_W(8), .BYTE_W(8), .IR_BYTES(1), .STK_DEPTH(4)) dut_w_i (
      .clk(clk), .rst_n(rst_w_n), .start_addr(SW),
      .mem_addr(fw_addr), .mem_rdata(fw_rdata),
      .ex_done(1'b1), .ex_jump(1'b0), .ex_call(1'b0), .ex_ret(1'b0),
      .ex_target(8'h00), .fetch_done(fw_done), .ir_q(fw_ir),
      .pc_q(fw_pc), .stk_err(fw_err)
   );

   initial begin
      repeat (3) @(negedge clk);
      rst_w_n = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         logic [7:0] a;
         a = SW + 8'(k - 1);
         do @(negedge clk); while (!fw_done);
         chk(fw_ir == memf(a), "R4 one-byte ir", fw_ir, memf(a));
         chk(fw_pc == a + 8'd1, "R4 one-byte pc", fw_pc, a + 8'd1);
      end
      chk(fw_err == 1'b0, "R13 no error in sequential run", fw_err, 0);
      nar_done = 1'b1;
   end

   // ---------------- reference model ----------------
   logic [7:0] m_pc;
   logic [7:0] m_stk [8];
   int         m_sp;
   bit         m_err;

   task automatic check_fetch(input string req);
      logic [15:0] e_ir;
      e_ir = {memf(m_pc + 8'd1), memf(m_pc)};
      chk(ir_q == e_ir, {req, " R3 ir bytes"}, ir_q, e_ir);
      m_pc = m_pc + 8'd2;
      chk(pc_q == m_pc, {req, " R3 pc after fetch"}, pc_q, m_pc);
   endtask

   // called at a negedge where fetch_done is high
   task automatic do_exec(input bit j, input bit c, input bit r,
                          input logic [7:0] tgt, input string req);
      int cnt;
      ex_jump = j; ex_call = c; ex_ret = r; ex_target = tgt; ex_done = 1'b1;
      if (c) begin
         if (m_sp == 8) m_err = 1'b1;
         else begin m_stk[m_sp] = m_pc; m_sp++; m_pc = tgt; end
      end else if (r) begin
         if (m_sp == 0) m_err = 1'b1;
         else begin m_sp--; m_pc = m_stk[m_sp]; end
      end else if (j) begin
         m_pc = tgt;
      end
      @(negedge clk);
      ex_done = 0; ex_jump = 0; ex_call = 0; ex_ret = 0;
      chk(pc_q == m_pc, {req, " pc after execute"}, pc_q, m_pc);
      chk(stk_err == m_err, {req, " error flag"}, stk_err, m_err);
      cnt = 1;
      while (!fetch_done) begin
         @(negedge clk);
         cnt++;
         if (cnt == 2) chk(mem_addr == m_pc, "R2 mem_addr follows pc", mem_addr, m_pc);
      end
      chk(cnt == 9, "R2 fetch length", cnt, 9);
      check_fetch(req);
   endtask

   initial begin
      m_sp = 0; m_err = 0;
      repeat (3) @(negedge clk);
      chk(pc_q == 8'h40, "R1 reset pc", pc_q, 8'h40);
      chk(ir_q == 16'h0, "R1 reset ir", ir_q, 0);
      chk(fetch_done == 1'b0, "R1 reset done", fetch_done, 0);
      chk(stk_err == 1'b0, "R1 reset err", stk_err, 0);
      m_pc = 8'h40;
      rst_n = 1'b1;
      do @(negedge clk); while (!fetch_done);
      check_fetch("R3 first");

      // R5: hold while waiting for ex_done
      begin
         logic [15:0] ir_s;
         ir_s = ir_q;
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(fetch_done == 1'b0, "R5 done single cycle", fetch_done, 0);
            chk(pc_q == m_pc, "R5 pc holds", pc_q, m_pc);
            chk(ir_q == ir_s, "R5 ir holds", ir_q, ir_s);
         end
      end

      do_exec(0, 0, 0, 8'h00, "R13 sequential");
      do_exec(0, 0, 0, 8'hAA, "R13 target ignored");
      do_exec(1, 0, 0, 8'h80, "R6 jump");
      do_exec(1, 0, 0, 8'hFF, "R6 jump to wrap");

      // R7: nested calls up to full depth
      for (int i = 0; i < 8; i++)
         do_exec(0, 1, 0, 8'(8'h10 + 8'(i * 20)), "R7 call");
      do_exec(0, 1, 0, 8'hC0, "R9 call on full stack");
      do_exec(1, 1, 1, 8'hC4, "R9 R12 combined on full stack");
      // R8: unwind in reverse order
      for (int i = 0; i < 8; i++)
         do_exec(0, 0, 1, 8'h00, "R8 return");
      do_exec(0, 0, 1, 8'h33, "R10 return on empty stack");
      do_exec(0, 0, 0, 8'h00, "R11 error stays set");
      do_exec(1, 1, 0, 8'h60, "R12 call over jump");
      do_exec(1, 0, 1, 8'h70, "R12 return over jump");
      do_exec(0, 1, 1, 8'h90, "R12 call over return");
      chk(stk_err == 1'b1, "R11 sticky before reset", stk_err, 1);

      // second reset across the address wrap
      @(negedge clk);
      rst_n = 1'b0; start_addr = 8'hFE;
      @(negedge clk);
      chk(stk_err == 1'b0, "R1 R11 reset clears error", stk_err, 0);
      chk(pc_q == 8'hFE, "R1 reset reloads start", pc_q, 8'hFE);
      m_pc = 8'hFE; m_sp = 0; m_err = 0;
      rst_n = 1'b1;
      do @(negedge clk); while (!fetch_done);
      check_fetch("R3 wrap");
      do_exec(0, 0, 1, 8'h00, "R10 stack emptied by reset");
      main_done = 1'b1;
   end

   initial begin
      wait (main_done && nar_done);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule